// File: doc/BRIEF.md
# Reset and NMI Entry Sequencer

This block drives the bus cycles that a small 8-bit processor core runs when it comes out of reset and when it takes a non-maskable interrupt. On leaving reset it stays quiet for a fixed number of cycles. It then reads a two-byte start vector and hands the result to the core as the new program counter. While the core runs, it watches the active-low NMI line. The line must be low for a minimum number of consecutive cycles before a request is latched, and the line must go high again before a later request can be seen.

A latched request waits for the core's instruction-boundary strobe. The block then writes three bytes to the stack page: the program counter high byte, the program counter low byte, and the status byte, in that order. It reads the NMI vector and finishes with a one-cycle done strobe. That strobe carries the new program counter, the stack pointer after the pushes, and a request to set the interrupt-mask flag.

All outputs are registered. Memory is read combinationally: the byte on `rdata_i` is taken at the clock edge that ends the cycle whose address is on `addr_o`.

Top module: `rst_nmi_entry`

## Requirements
- R1: While `rst` is high, the block holds its idle state: `bus_act_o`=0, `rw_o`=1 (read), `done_o`=0, `iflag_set_o`=0, `sp_o`=0.
- R2: After `rst` is released, the first six cycles carry no bus activity. The seventh cycle reads address 0xFFFC (`bus_act_o`=1, `rw_o`=1).
- R3: The eighth cycle after release reads 0xFFFD. In the ninth cycle, `done_o` is 1, `bus_act_o` is 0, and `pc_o` holds {byte read at 0xFFFD, byte read at 0xFFFC}.
- R4: An NMI request is latched only after `nmi_n` has been sampled low on two consecutive clock edges. A low pulse of a single cycle has no effect.
- R5: After a request has been latched, holding `nmi_n` low produces no second entry. The line must be sampled high at least once and then low again to make a new request.
- R6: A latched request starts an entry only on an edge where `insn_end_i` is 1. The request stays latched even if `nmi_n` returns high before that edge.
- R7: The entry starts with three write cycles (`rw_o`=0) to addresses 0x0100+SP, 0x0100+SP-1 and 0x0100+SP-2. The offsets wrap within the low byte. The bytes written are PC[15:8], PC[7:0] and the status byte, in that order. SP, PC and status are the inputs sampled at the accepting edge.
- R8: The writes are followed by reads of 0xFFFA and then 0xFFFB. In the next cycle, `done_o`=1, `iflag_set_o`=1, `pc_o`={byte at 0xFFFB, byte at 0xFFFA} and `sp_o`=SP-3 (mod 256). `iflag_set_o` is never 1 outside an NMI done cycle.
- R9: Reset overrides everything. It aborts an entry in progress and discards a latched request, so no entry follows the next boot.
- R10: The value of the status byte, including a set mask bit (bit 2), never blocks an NMI entry.
- R11: `done_o` is high for exactly one cycle per completed sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| nmi_n | input | 1 | Non-maskable interrupt line, active low |
| insn_end_i | input | 1 | Core is at an instruction boundary |
| pc_i | input | 16 | Core program counter |
| sp_i | input | 8 | Core stack pointer |
| status_i | input | 8 | Core status byte |
| rdata_i | input | 8 | Read data for the current address |
| addr_o | output | 16 | Address bus |
| wdata_o | output | 8 | Write data |
| rw_o | output | 1 | 1 = read, 0 = write |
| bus_act_o | output | 1 | A bus cycle is driven this cycle |
| sp_o | output | 8 | Stack pointer after the NMI pushes |
| iflag_set_o | output | 1 | Set the interrupt-mask flag (with done) |
| pc_o | output | 16 | New program counter (with done) |
| done_o | output | 1 | Sequence complete, one-cycle strobe |

## Verification
Every result has a fixed cycle offset from its stimulus. The start vector is read exactly seven edges after reset is released, and done follows two edges later. When NMI falls on a boundary cycle, the first push appears on the third edge after the fall and done on the eighth. A stalled request appears on the first edge that sees the boundary strobe. The bench samples each output at the falling edge that follows the edge where the output is due. It also checks the quiet cycles before that edge, so a result that comes one cycle early or one cycle late is reported.

// File: rtl/rne_pkg.sv
package rne_pkg;
  // Each state names what the bus is doing during the current cycle.
  typedef enum logic [3:0] {
    ST_BOOT,
    ST_RVL,
    ST_RVH,
    ST_IDLE,
    ST_PUSH_PCH,
    ST_PUSH_PCL,
    ST_PUSH_ST,
    ST_NVL,
    ST_NVH
  } seq_st_e;

  function automatic logic [15:0] stack_addr(input logic [7:0] page, input logic [7:0] ptr);
    return {page, ptr};
  endfunction
endpackage

// File: rtl/rne_nmi_gate.sv
module rne_nmi_gate #(
  parameter int MIN_LOW = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic take,
  output logic pending
);
  localparam int CW = (MIN_LOW < 2) ? 1 : $clog2(MIN_LOW + 1);

  logic armed;

  generate
    if (MIN_LOW <= 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          armed   <= 1'b1;
          pending <= 1'b0;
        end else begin
          if (take) pending <= 1'b0;
          if (nmi_n) begin
            armed <= 1'b1;
          end else if (armed) begin
            pending <= 1'b1;
            armed   <= 1'b0;
          end
        end
      end
    end else begin : g_count
      logic [CW-1:0] low_cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          armed   <= 1'b1;
          pending <= 1'b0;
          low_cnt <= '0;
        end else begin
          if (take) pending <= 1'b0;
          if (nmi_n) begin
            low_cnt <= '0;
            armed   <= 1'b1;
          end else begin
            if (low_cnt != CW'(MIN_LOW)) low_cnt <= low_cnt + 1'b1;
            if (armed && (low_cnt == CW'(MIN_LOW - 1))) begin
              pending <= 1'b1;
              armed   <= 1'b0;
            end
          end
        end
      end
    end
  endgenerate
endmodule

// File: rtl/rne_boot_timer.sv
module rne_boot_timer #(
  parameter int DELAY = 6
) (
  input  logic clk,
  input  logic rst,
  output logic go
);
  localparam int CW = (DELAY < 1) ? 1 : $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          fired;

  assign go = (cnt == CW'(DELAY)) && !fired;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fired <= 1'b0;
    end else begin
      if (cnt != CW'(DELAY)) cnt <= cnt + 1'b1;
      if (go) fired <= 1'b1;
    end
  end
endmodule

// File: rtl/rne_seq.sv
module rne_seq
  import rne_pkg::*;
#(
  parameter int          DATA_W     = 8,
  parameter int          ADDR_W     = 16,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_NMI    = 16'hFFFA,
  parameter logic [15:0] VEC_RST    = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_go,
  input  logic              pending,
  input  logic              insn_end,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] sp_i,
  input  logic [DATA_W-1:0] status_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              take,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rw_o,
  output logic              bus_act_o,
  output logic [DATA_W-1:0] sp_o,
  output logic              iflag_set_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic              done_o
);
  localparam logic [ADDR_W-1:0] VEC_RST_HI = ADDR_W'(VEC_RST + 16'd1);
  localparam logic [ADDR_W-1:0] VEC_NMI_HI = ADDR_W'(VEC_NMI + 16'd1);

  seq_st_e           st;
  logic [DATA_W-1:0] vec_lo;
  logic [DATA_W-1:0] sp_w;
  logic [DATA_W-1:0] pcl_l;
  logic [DATA_W-1:0] stat_l;

  assign take = (st == ST_IDLE) && pending && insn_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_BOOT;
      addr_o      <= '0;
      wdata_o     <= '0;
      rw_o        <= 1'b1;
      bus_act_o   <= 1'b0;
      sp_o        <= '0;
      iflag_set_o <= 1'b0;
      pc_o        <= '0;
      done_o      <= 1'b0;
      vec_lo      <= '0;
      sp_w        <= '0;
      pcl_l       <= '0;
      stat_l      <= '0;
    end else begin
      done_o      <= 1'b0;
      iflag_set_o <= 1'b0;
      case (st)
        ST_BOOT: begin
          if (boot_go) begin
            st        <= ST_RVL;
            addr_o    <= VEC_RST;
            rw_o      <= 1'b1;
            bus_act_o <= 1'b1;
          end
        end
        ST_RVL: begin
          vec_lo <= rdata_i;
          addr_o <= VEC_RST_HI;
          st     <= ST_RVH;
        end
        ST_RVH: begin
          pc_o      <= {rdata_i, vec_lo};
          done_o    <= 1'b1;
          bus_act_o <= 1'b0;
          addr_o    <= '0;
          st        <= ST_IDLE;
        end
        ST_IDLE: begin
          if (take) begin
            addr_o    <= stack_addr(STACK_PAGE, sp_i);
            wdata_o   <= pc_i[ADDR_W-1:DATA_W];
            rw_o      <= 1'b0;
            bus_act_o <= 1'b1;
            sp_w      <= sp_i - 1'b1;
            pcl_l     <= pc_i[DATA_W-1:0];
            stat_l    <= status_i;
            st        <= ST_PUSH_PCH;
          end
        end
        ST_PUSH_PCH: begin
          addr_o  <= stack_addr(STACK_PAGE, sp_w);
          wdata_o <= pcl_l;
          sp_w    <= sp_w - 1'b1;
          st      <= ST_PUSH_PCL;
        end
        ST_PUSH_PCL: begin
          addr_o  <= stack_addr(STACK_PAGE, sp_w);
          wdata_o <= stat_l;
          sp_w    <= sp_w - 1'b1;
          st      <= ST_PUSH_ST;
        end
        ST_PUSH_ST: begin
          addr_o  <= VEC_NMI;
          wdata_o <= '0;
          rw_o    <= 1'b1;
          st      <= ST_NVL;
        end
        ST_NVL: begin
          vec_lo <= rdata_i;
          addr_o <= VEC_NMI_HI;
          st     <= ST_NVH;
        end
        ST_NVH: begin
          pc_o        <= {rdata_i, vec_lo};
          sp_o        <= sp_w;
          done_o      <= 1'b1;
          iflag_set_o <= 1'b1;
          bus_act_o   <= 1'b0;
          addr_o      <= '0;
          st          <= ST_IDLE;
        end
        default: st <= ST_BOOT;
      endcase
    end
  end
endmodule

// File: rtl/rst_nmi_entry.sv
module rst_nmi_entry #(
  parameter int          RST_DELAY   = 6,
  parameter int          NMI_MIN_LOW = 2,
  parameter logic [7:0]  STACK_PAGE  = 8'h01,
  parameter logic [15:0] VEC_NMI     = 16'hFFFA,
  parameter logic [15:0] VEC_RST     = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        nmi_n,
  input  logic        insn_end_i,
  input  logic [15:0] pc_i,
  input  logic [7:0]  sp_i,
  input  logic [7:0]  status_i,
  input  logic [7:0]  rdata_i,
  output logic [15:0] addr_o,
  output logic [7:0]  wdata_o,
  output logic        rw_o,
  output logic        bus_act_o,
  output logic [7:0]  sp_o,
  output logic        iflag_set_o,
  output logic [15:0] pc_o,
  output logic        done_o
);
  localparam int DW = 8;
  localparam int AW = 2 * DW;

  logic boot_go;
  logic pending;
  logic take;

  rne_boot_timer #(.DELAY(RST_DELAY)) boot_i (
    .clk (clk),
    .rst (rst),
    .go  (boot_go)
  );

  rne_nmi_gate #(.MIN_LOW(NMI_MIN_LOW)) gate_i (
    .clk     (clk),
    .rst     (rst),
    .nmi_n   (nmi_n),
    .take    (take),
    .pending (pending)
  );

  rne_seq #(
    .DATA_W     (DW),
    .ADDR_W     (AW),
    .STACK_PAGE (STACK_PAGE),
    .VEC_NMI    (VEC_NMI),
    .VEC_RST    (VEC_RST)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .boot_go     (boot_go),
    .pending     (pending),
    .insn_end    (insn_end_i),
    .pc_i        (pc_i),
    .sp_i        (sp_i),
    .status_i    (status_i),
    .rdata_i     (rdata_i),
    .take        (take),
    .addr_o      (addr_o),
    .wdata_o     (wdata_o),
    .rw_o        (rw_o),
    .bus_act_o   (bus_act_o),
    .sp_o        (sp_o),
    .iflag_set_o (iflag_set_o),
    .pc_o        (pc_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/rst_nmi_entry_chk.sv
module rst_nmi_entry_chk #(
  parameter int          RST_DELAY  = 6,
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [15:0] VEC_RST    = 16'hFFFC
) (
  input logic        clk,
  input logic        rst,
  input logic        insn_end_i,
  input logic [15:0] addr_o,
  input logic        rw_o,
  input logic        bus_act_o,
  input logic        done_o,
  input logic        iflag_set_o
);
  int unsigned since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= 0;
    else if (since_rst < 32'd1000000) since_rst <= since_rst + 1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!bus_act_o && rw_o && !done_o && !iflag_set_o));

  a_r2_boot_delay: assert property (@(posedge clk) disable iff (rst)
    (bus_act_o && rw_o && addr_o == VEC_RST) |-> (since_rst > RST_DELAY));

  a_r6_accept_on_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(rw_o) |-> $past(insn_end_i));

  a_r7_writes_in_stack: assert property (@(posedge clk) disable iff (rst)
    (bus_act_o && !rw_o) |-> (addr_o[15:8] == STACK_PAGE));

  a_r7_stack_descends: assert property (@(posedge clk) disable iff (rst)
    (bus_act_o && !rw_o && $past(bus_act_o && !rw_o)) |->
      (addr_o[7:0] == 8'($past(addr_o[7:0]) - 8'd1)));

  a_r8_mask_with_done: assert property (@(posedge clk) disable iff (rst)
    iflag_set_o |-> done_o);

  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

bind rst_nmi_entry rst_nmi_entry_chk #(
  .RST_DELAY  (RST_DELAY),
  .STACK_PAGE (STACK_PAGE),
  .VEC_RST    (VEC_RST)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .insn_end_i  (insn_end_i),
  .addr_o      (addr_o),
  .rw_o        (rw_o),
  .bus_act_o   (bus_act_o),
  .done_o      (done_o),
  .iflag_set_o (iflag_set_o)
);

// File: tb/rst_nmi_entry_tb_top.sv
`timescale 1ns/1ps
module rst_nmi_entry_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        nmi_n;
  logic        insn_end_i;
  logic [15:0] pc_i;
  logic [7:0]  sp_i;
  logic [7:0]  status_i;
  logic [7:0]  rdata_i;
  logic [15:0] addr_o;
  logic [7:0]  wdata_o;
  logic        rw_o;
  logic        bus_act_o;
  logic [7:0]  sp_o;
  logic        iflag_set_o;
  logic [15:0] pc_o;
  logic        done_o;

  int n_cmp = 0;
  int n_bad = 0;

  localparam logic [15:0] RST_PC = 16'hABCD;
  localparam logic [15:0] NMI_PC = 16'h1234;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_rd(input logic [15:0] a);
    case (a)
      16'hFFFA: return NMI_PC[7:0];
      16'hFFFB: return NMI_PC[15:8];
      16'hFFFC: return RST_PC[7:0];
      16'hFFFD: return RST_PC[15:8];
      default:  return a[7:0] ^ 8'h5A;
    endcase
  endfunction

  assign rdata_i = mem_rd(addr_o);

  rst_nmi_entry dut_i (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .insn_end_i(insn_end_i),
    .pc_i(pc_i), .sp_i(sp_i), .status_i(status_i), .rdata_i(rdata_i),
    .addr_o(addr_o), .wdata_o(wdata_o), .rw_o(rw_o), .bus_act_o(bus_act_o),
    .sp_o(sp_o), .iflag_set_o(iflag_set_o), .pc_o(pc_o), .done_o(done_o)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot();
    rst = 1'b1;
    tick();
    tick();
    chk("R1 bus_act", 32'(bus_act_o), 32'd0);
    chk("R1 rw", 32'(rw_o), 32'd1);
    chk("R1 done", 32'(done_o), 32'd0);
    chk("R1 iflag", 32'(iflag_set_o), 32'd0);
    chk("R1 sp_o", 32'(sp_o), 32'd0);
    rst = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk("R2 quiet", 32'(bus_act_o), 32'd0);
    end
    tick();
    chk("R2 addr", 32'(addr_o), 32'hFFFC);
    chk("R2 act", 32'({bus_act_o, rw_o}), 32'b11);
    tick();
    chk("R3 addr", 32'(addr_o), 32'hFFFD);
    chk("R3 act", 32'({bus_act_o, rw_o}), 32'b11);
    tick();
    chk("R3 done", 32'({done_o, bus_act_o}), 32'b10);
    chk("R3 pc", 32'(pc_o), 32'(RST_PC));
    chk("R8 no iflag on boot", 32'(iflag_set_o), 32'd0);
    tick();
    chk("R11 done drop", 32'(done_o), 32'd0);
  endtask

  // Pushes and vector reads starting from a cycle whose write shows SP.
  task automatic expect_entry(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
    chk("R7 addr0", 32'(addr_o), 32'({8'h01, sp}));
    chk("R7 data0", 32'(wdata_o), 32'(pc[15:8]));
    chk("R7 w0", 32'({bus_act_o, rw_o}), 32'b10);
    tick();
    chk("R7 addr1", 32'(addr_o), 32'({8'h01, 8'(sp - 8'd1)}));
    chk("R7 data1", 32'(wdata_o), 32'(pc[7:0]));
    chk("R7 w1", 32'({bus_act_o, rw_o}), 32'b10);
    tick();
    chk("R7 addr2", 32'(addr_o), 32'({8'h01, 8'(sp - 8'd2)}));
    chk("R10 data2", 32'(wdata_o), 32'(st));
    chk("R7 w2", 32'({bus_act_o, rw_o}), 32'b10);
    tick();
    chk("R8 vlo", 32'({addr_o, bus_act_o, rw_o}), 32'({16'hFFFA, 2'b11}));
    tick();
    chk("R8 vhi", 32'({addr_o, bus_act_o, rw_o}), 32'({16'hFFFB, 2'b11}));
    tick();
    chk("R8 done", 32'({done_o, iflag_set_o, bus_act_o}), 32'b110);
    chk("R8 pc", 32'(pc_o), 32'(NMI_PC));
    chk("R8 sp", 32'(sp_o), 32'(8'(sp - 8'd3)));
    tick();
    chk("R11 done drop", 32'({done_o, iflag_set_o}), 32'b00);
  endtask

  task automatic nmi_run(input logic [15:0] pc, input logic [7:0] sp, input logic [7:0] st);
    pc_i = pc; sp_i = sp; status_i = st;
    insn_end_i = 1'b1;
    nmi_n = 1'b0;
    tick();
    chk("R4 first low", 32'(bus_act_o), 32'd0);
    tick();
    chk("R4 second low", 32'(bus_act_o), 32'd0);
    tick();
    expect_entry(pc, sp, st);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R5 held low", 32'(bus_act_o), 32'd0);
    end
    nmi_n = 1'b1;
    tick();
  endtask

  initial begin
    logic [7:0]  sps [6];
    logic [15:0] pcs [4];
    logic [7:0]  sts [3];
    sps = '{8'h00, 8'h01, 8'h02, 8'h80, 8'hFD, 8'hFF};
    pcs = '{16'h0000, 16'hFFFF, 16'hA55A, 16'h1FFE};
    sts = '{8'h00, 8'h04, 8'hFF};
    rst = 1'b1; nmi_n = 1'b1; insn_end_i = 1'b0;
    pc_i = '0; sp_i = 8'hFF; status_i = '0;
    boot();

    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 4; b++)
        for (int c = 0; c < 3; c++)
          nmi_run(pcs[b], sps[a], sts[c]);

    // R4: single-cycle low pulse is ignored
    nmi_n = 1'b0;
    tick();
    nmi_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R4 short pulse", 32'(bus_act_o), 32'd0);
    end

    // R6: request waits for boundary, survives line going high
    pc_i = 16'h4321; sp_i = 8'h40; status_i = 8'h04;
    insn_end_i = 1'b0;
    nmi_n = 1'b0;
    tick();
    tick();
    nmi_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk("R6 stalled", 32'(bus_act_o), 32'd0);
    end
    insn_end_i = 1'b1;
    tick();
    expect_entry(16'h4321, 8'h40, 8'h04);

    // R5: re-arm after a single high sample
    nmi_n = 1'b0;
    tick(); tick(); tick();
    expect_entry(16'h4321, 8'h40, 8'h04);
    nmi_n = 1'b1;
    tick();
    nmi_n = 1'b0;
    tick(); tick(); tick();
    chk("R5 rearm", 32'({bus_act_o, rw_o}), 32'b10);
    expect_entry(16'h4321, 8'h40, 8'h04);
    nmi_n = 1'b1;
    tick();

    // R9: latched request discarded by reset
    insn_end_i = 1'b0;
    nmi_n = 1'b0;
    tick(); tick();
    nmi_n = 1'b1;
    insn_end_i = 1'b1;
    boot();
    for (int k = 0; k < 3; k++) begin
      chk("R9 no stale entry", 32'(bus_act_o), 32'd0);
      tick();
    end

    // R9: reset aborts an entry in progress
    nmi_n = 1'b0;
    tick(); tick(); tick();
    chk("R9 entry begun", 32'({bus_act_o, rw_o}), 32'b10);
    rst = 1'b1;
    tick();
    chk("R9 abort", 32'({bus_act_o, rw_o, done_o}), 32'b010);
    nmi_n = 1'b1;
    boot();
    for (int k = 0; k < 3; k++) begin
      chk("R9 no resume", 32'(bus_act_o), 32'd0);
      tick();
    end

    summary();
    $finish;
  end
endmodule